// File: doc/BRIEF.md
# Clock Ratio Sampling Speed Detector

This block works out how many master clock cycles make up one period of the left/right frame clock. From that ratio it derives the audio sampling speed class. It lives entirely in the master clock domain. The asynchronous frame clock passes through a two-stage synchroniser, and its rising edges are detected after that.

The interval between successive rising edges is counted and matched against the supported ratios 128, 192, 256, 384, 512, 768 and 1152 master clocks per frame, with a small tolerance. A ratio is only reported once the same ratio has been seen on several consecutive periods. A supported ratio that does not match the current lock is tolerated for a single period. A measured period that matches no supported ratio raises an error flag.

The speed classes are:
- 128 and 192 are quad speed.
- 256 and 384 are double speed.
- 512 and 768 are normal speed.
- 1152 is also normal speed, and is only meant for the lowest sample rate.

The downstream datapath uses the reported class to choose its speed automatically.

Top module: `clk_ratio_detect`

## Requirements
- R1: While locked on 128 (ratio_o=0) or 192 (ratio_o=1) master clocks per frame, speed_o is 2'b10 (quad).
- R2: While locked on 256 (ratio_o=2) or 384 (ratio_o=3), speed_o is 2'b01 (double).
- R3: While locked on 512 (ratio_o=4), 768 (ratio_o=5) or 1152 (ratio_o=6), speed_o is 2'b00 (normal).
- R4: A period is counted in master clock cycles from one synchronised rising frame edge to the next. It matches a ratio when it lies within ±2 cycles of the nominal value. A period 3 or more cycles away from every nominal value is unsupported.
- R5: The partial period that follows reset or a timeout is discarded. locked_o rises after 4 consecutive measured periods match the same supported ratio, and not after 3. Periods that alternate between two supported ratios never lock.
- R6: While locked, a single mismatching period keeps the lock. 2 consecutive mismatching periods drop it.
- R7: While unlocked (including after reset), ratio_o is 3'd7 and speed_o is 2'b11.
- R8: err_o is set when the last measured period was unsupported or a timeout occurred. It is cleared by a supported measured period. err_o is 0 after reset.
- R9: If no rising frame edge arrives for 2^CNT_W-1 master clock cycles (4095 by default), the lock is dropped and err_o is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Left/right frame clock, asynchronous to clk_i |
| ratio_o | output | 3 | Locked ratio code 0..6, 7 when unlocked |
| speed_o | output | 2 | Speed class: 00 normal, 01 double, 10 quad, 11 none |
| locked_o | output | 1 | Ratio locked |
| err_o | output | 1 | Last period unsupported or frame clock stalled |

## Verification
A miscounting period counter shows up at the measurement that ends the first full period. A tolerance test at ±2 and ±3 cycles then fails to lock or raises err_o within one frame period. A wrong run or miss counter in the lock tracker shifts the edge of locked_o by a whole frame period. That is caught by sampling just before and just after the fourth and second qualifying period. A wrong speed table shows on speed_o as soon as the lock is reported.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_NONE   = 2'b11
  } speed_e;

  localparam int unsigned NUM_RATIOS = 7;
  localparam logic [2:0]  CODE_NONE  = 3'd7;

  function automatic int unsigned ratio_nominal(int unsigned idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

  function automatic speed_e ratio_speed(logic [2:0] code);
    case (code)
      3'd0, 3'd1:       return SPD_QUAD;
      3'd2, 3'd3:       return SPD_DOUBLE;
      3'd4, 3'd5, 3'd6: return SPD_NORMAL;
      default:          return SPD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cr_period_count.sv
module cr_period_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      done_o    <= 1'b0;
      meas_o    <= '0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (rise_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        // first edge after reset/timeout only arms
        if (armed_q) begin
          done_o <= 1'b1;
          meas_o <= cnt_q + 1'b1;
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX - 1'b1) begin
          timeout_o <= 1'b1;
          armed_q   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cr_classify.sv
module cr_classify #(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] meas_i,
  output logic [2:0]       code_o
);
  import cr_pkg::*;

  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_hit
    localparam int unsigned NOM = ratio_nominal(i);
    assign hit[i] = (meas_i >= CNT_W'(NOM - TOL)) && (meas_i <= CNT_W'(NOM + TOL));
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code_o = 3'(i);
    end
  end
endmodule

// File: rtl/cr_lock.sv
module cr_lock #(
  parameter int LOCK_RUN = 4,
  parameter int DROP_RUN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [2:0] code_i,
  input  logic       timeout_i,
  output logic       locked_o,
  output logic [2:0] code_o,
  output logic       err_o
);
  import cr_pkg::*;

  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int MISS_W = $clog2(DROP_RUN + 1);

  logic [RUN_W-1:0]  run_q;
  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      code_o   <= CODE_NONE;
      err_o    <= 1'b0;
      run_q    <= '0;
      miss_q   <= '0;
    end else if (timeout_i) begin
      locked_o <= 1'b0;
      code_o   <= CODE_NONE;
      err_o    <= 1'b1;
      run_q    <= '0;
      miss_q   <= '0;
    end else if (done_i) begin
      err_o <= (code_i == CODE_NONE);
      if (locked_o) begin
        if (code_i == code_o) begin
          miss_q <= '0;
        end else if (miss_q == MISS_W'(DROP_RUN - 1)) begin
          locked_o <= 1'b0;
          miss_q   <= '0;
          code_o   <= code_i;
          run_q    <= (code_i != CODE_NONE) ? RUN_W'(1) : '0;
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end else if (code_i == CODE_NONE) begin
        code_o <= CODE_NONE;
        run_q  <= '0;
      end else if (code_i == code_o) begin
        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          locked_o <= 1'b1;
          run_q    <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        code_o <= code_i;
        run_q  <= RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect #(
  parameter int CNT_W    = 12,
  parameter int TOL      = 2,
  parameter int SYNC_STG = 2,
  parameter int LOCK_RUN = 4,
  parameter int DROP_RUN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  output logic [2:0] ratio_o,
  output logic [1:0] speed_o,
  output logic       locked_o,
  output logic       err_o
);
  import cr_pkg::*;

  logic             rise;
  logic             done;
  logic             timeout;
  logic [CNT_W-1:0] meas;
  logic [2:0]       meas_code;
  logic [2:0]       lock_code;
  logic             locked;

  cr_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(frame_i), .rise_o(rise)
  );

  cr_period_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .done_o(done), .meas_o(meas), .timeout_o(timeout)
  );

  cr_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .meas_i(meas), .code_o(meas_code)
  );

  cr_lock #(.LOCK_RUN(LOCK_RUN), .DROP_RUN(DROP_RUN)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .code_i(meas_code),
    .timeout_i(timeout), .locked_o(locked), .code_o(lock_code), .err_o(err_o)
  );

  assign locked_o = locked;
  assign ratio_o  = locked ? lock_code : CODE_NONE;
  assign speed_o  = locked ? ratio_speed(lock_code) : SPD_NONE;
endmodule

// File: rtl/clk_ratio_detect_chk.sv
module clk_ratio_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] ratio_o,
  input logic [1:0] speed_o,
  input logic       locked_o,
  input logic       err_o
);
  assert_unlocked_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (ratio_o == 3'd7 && speed_o == 2'b11));

  assert_quad_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && ratio_o < 3'd2) |-> speed_o == 2'b10);

  assert_double_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && (ratio_o == 3'd2 || ratio_o == 3'd3)) |-> speed_o == 2'b01);

  assert_normal_map_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && ratio_o >= 3'd4) |-> speed_o == 2'b00);

  assert_lock_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> !err_o);

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(ratio_o));

  assert_lock_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> ratio_o != 3'd7);
endmodule

bind clk_ratio_detect clk_ratio_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ratio_o(ratio_o),
  .speed_o(speed_o), .locked_o(locked_o), .err_o(err_o)
);

// File: tb/clk_ratio_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [2:0] ratio_o;
  logic [1:0] speed_o;
  logic       locked_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  clk_ratio_detect u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
    .ratio_o(ratio_o), .speed_o(speed_o), .locked_o(locked_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    frame_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // one frame period of n clocks, starting with a rising edge
  task automatic gen_period(input int n);
    @(negedge clk_i);
    frame_i = 1'b1;
    repeat (n / 2) @(negedge clk_i);
    frame_i = 1'b0;
    repeat (n - n / 2 - 1) @(negedge clk_i);
  endtask

  task automatic expect_state(input string req, input bit lk, input int code,
                              input int spd, input bit er);
    check(locked_o == lk, req, "locked_o", locked_o, lk);
    check(ratio_o == code, req, "ratio_o", ratio_o, code);
    check(speed_o == spd, req, "speed_o", speed_o, spd);
    check(err_o == er, req, "err_o", err_o, er);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_state("R7", 1'b0, 7, 3, 1'b0);
  endtask

  task automatic t_lock_ratio(input int n, input int code, input int spd, input string req);
    do_reset();
    repeat (4) gen_period(n);
    check(locked_o == 1'b0, "R5", "locked after 3 periods", locked_o, 0);
    gen_period(n);
    expect_state(req, 1'b1, code, spd, 1'b0);
  endtask

  task automatic t_tolerance();
    do_reset();
    repeat (5) gen_period(386);
    expect_state("R4", 1'b1, 3, 1, 1'b0);
    do_reset();
    repeat (5) gen_period(254);
    expect_state("R4", 1'b1, 2, 1, 1'b0);
    do_reset();
    repeat (5) gen_period(771);
    expect_state("R4", 1'b0, 7, 3, 1'b1);
    do_reset();
    repeat (5) gen_period(125);
    expect_state("R4", 1'b0, 7, 3, 1'b1);
  endtask

  task automatic t_alternate();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      gen_period(512);
      gen_period(768);
    end
    expect_state("R5", 1'b0, 7, 3, 1'b0);
  endtask

  task automatic t_drop();
    do_reset();
    repeat (5) gen_period(256);
    expect_state("R6", 1'b1, 2, 1, 1'b0);
    gen_period(300);
    gen_period(256);  // measures 300: first miss
    expect_state("R6", 1'b1, 2, 1, 1'b1);
    gen_period(300);  // measures 256: miss cleared, err cleared
    check(err_o == 1'b0, "R8", "err_o after supported period", err_o, 0);
    gen_period(300);  // measures 300: first miss
    check(locked_o == 1'b1, "R6", "locked after single miss", locked_o, 1);
    gen_period(256);  // measures 300: second miss
    expect_state("R6", 1'b0, 7, 3, 1'b1);
  endtask

  task automatic t_timeout();
    do_reset();
    repeat (5) gen_period(128);
    expect_state("R1", 1'b1, 0, 2, 1'b0);
    repeat (4200) @(negedge clk_i);
    expect_state("R9", 1'b0, 7, 3, 1'b1);
    repeat (4) gen_period(192);
    check(locked_o == 1'b0, "R5", "locked right after timeout", locked_o, 0);
    gen_period(192);
    expect_state("R9", 1'b1, 1, 2, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_lock_ratio(128, 0, 2, "R1");
    t_lock_ratio(192, 1, 2, "R1");
    t_lock_ratio(256, 2, 1, "R2");
    t_lock_ratio(384, 3, 1, "R2");
    t_lock_ratio(512, 4, 0, "R3");
    t_lock_ratio(768, 5, 0, "R3");
    t_lock_ratio(1152, 6, 0, "R3");
    t_tolerance();
    t_alternate();
    t_drop();
    t_timeout();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule